// File: doc/BRIEF.md
# ECC Error Injection and Accounting

This block sits between a memory controller and a 64-bit wide storage array. On the write side it computes eight check bits for each data word. These form a single-error-correcting, double-error-detecting code: seven Hamming bits plus one overall parity bit. A diagnostic path can XOR a programmable 64-bit injection mask into the data before it reaches storage. The check bits are always computed from the data before injection, so any mask bit that is set appears as a real error when the word is read back.

On the read side the block decodes the stored word and its check bits. A single flipped bit, in the data or in the check bits, is corrected. Two flipped bits are flagged as uncorrectable, and the raw data is passed through unchanged. Corrected reads advance an error counter. When the counter reaches a programmable threshold it returns to zero and sets a sticky flag. Further sticky flags record an uncorrectable read and a repeat occurrence of either event. A small register interface loads the two mask halves, the injection enable, the threshold and the counter, and clears the flags.

Top module: `ecc_inject_guard`

## Requirements
- R1: After reset, injection is off, both mask halves are zero, the threshold is 255, the counter is zero, all three flags are clear, and both output valids are low.
- R2: A write request appears on the storage outputs on the next clock edge, with eight check bits. While injection is disabled, the stored data equals the written data even when mask bits are programmed.
- R3: While injection is enabled, the stored data equals the written data XOR {high mask, low mask}. The check bits equal those produced for the same data without injection.
- R4: A read whose 72-bit codeword has exactly one flipped bit (any of the 64 data or 8 check positions) returns the original data with the corrected strobe one cycle later. One set mask bit in total therefore yields a corrected read.
- R5: A read with two flipped bits raises the uncorrectable strobe one cycle later and returns the read data unchanged. Two set mask bits, in one half or across both halves, therefore yield an uncorrectable read.
- R6: A read of an unmodified codeword returns its data with neither strobe. Neither strobe is ever raised without the read output valid.
- R7: Each corrected read adds one to the 8-bit counter. Clean and uncorrectable reads leave it unchanged. While the counter stays short of the threshold, the single-error flag stays clear.
- R8: A corrected read that would bring the counter to the threshold instead sets the counter to zero and sets the single-error flag.
- R9: If the threshold is reached while the single-error flag is already set, the repeat flag is set as well.
- R10: An uncorrectable read sets the multi-bit flag. The first one leaves the repeat flag clear; one arriving while the multi-bit flag is already set sets the repeat flag.
- R11: Register writes use these addresses: 0 low mask, 1 high mask, 2 bit 0 injection enable, 3 threshold in bits 7:0, 4 counter value in bits 7:0, 5 write-one-to-clear with bit 0 single-error flag, bit 1 multi-bit flag, bit 2 repeat flag. A counter write or flag clear takes priority over a read event in the same cycle.
- R12: The three flags hold their value through any number of reads until cleared by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_data | input | 64 | Data to be stored |
| mem_wr_valid | output | 1 | Write request toward storage |
| mem_wr_data | output | 64 | Stored data, injection applied |
| mem_wr_check | output | 8 | Check bits toward storage |
| rd_valid | input | 1 | Read data from storage is present |
| rd_data | input | 64 | Data read from storage |
| rd_check | input | 8 | Check bits read from storage |
| rd_out_valid | output | 1 | Decoded read result valid |
| rd_out_data | output | 64 | Corrected or passed-through read data |
| rd_corrected | output | 1 | A single-bit error was corrected |
| rd_uncorrectable | output | 1 | An uncorrectable error was detected |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| sb_count | output | 8 | Corrected-error counter |
| flag_sbe | output | 1 | Sticky threshold-reached flag |
| flag_mbe | output | 1 | Sticky uncorrectable-read flag |
| flag_multi | output | 1 | Sticky repeat-event flag |

## Verification
A wrong bit in the code-position mapping or the syndrome logic shows up on the very next read. Either corrected data comes back with a bit still flipped, or a single flip is misreported as uncorrectable. A sweep over every one of the 72 code positions, and over many bit pairs, exposes this within a few hundred cycles. A counter or flag that is off by one shows up at the threshold crossing: the counter fails to read zero, or the single-error flag is late. That appears within a handful of corrected reads once a small threshold is programmed. A flag that loses its sticky state shows up during the clean reads that follow it.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CODE_W = DATA_W + HAM_W;
    localparam int HALF_W = DATA_W / 2;
    localparam int REG_AW = 3;
    localparam int REG_DW = HALF_W;

    localparam logic [REG_AW-1:0] REG_MASK_LO = 3'd0;
    localparam logic [REG_AW-1:0] REG_MASK_HI = 3'd1;
    localparam logic [REG_AW-1:0] REG_CTRL    = 3'd2;
    localparam logic [REG_AW-1:0] REG_THRESH  = 3'd3;
    localparam logic [REG_AW-1:0] REG_COUNT   = 3'd4;
    localparam logic [REG_AW-1:0] REG_CLEAR   = 3'd5;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_SINGLE = 2'd1,
        ECC_DOUBLE = 2'd2
    } ecc_class_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } codeword_t;

    // Code position (1-based) of data bit idx: the idx-th position that is not a power of two.
    function automatic logic [31:0] data_pos(input int idx);
        logic [31:0] res;
        int          seen;
        res  = '0;
        seen = 0;
        for (int p = 3; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) res = 32'(p);
                seen++;
            end
        end
        return res;
    endfunction

    function automatic logic [HAM_W-1:0] hamming_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        logic [31:0]      pos;
        h = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos = data_pos(i);
            for (int j = 0; j < HAM_W; j++) begin
                if (pos[j]) h[j] = h[j] ^ d[i];
            end
        end
        return h;
    endfunction

    function automatic logic [CHK_W-1:0] gen_check(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = hamming_bits(d);
        return {(^d) ^ (^h), h};
    endfunction

endpackage

// File: rtl/ecc_inj_encoder.sv
module ecc_inj_encoder
    import ecc_inj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_en,
    input  logic [DATA_W-1:0] inj_mask,
    output logic              out_valid,
    output codeword_t         out_word
);

    logic [DATA_W-1:0] flip;

    assign flip = inj_en ? inj_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= wr_valid;
            if (wr_valid) begin
                out_word.data <= wr_data ^ flip;
                out_word.chk  <= gen_check(wr_data);
            end
        end
    end

endmodule

// File: rtl/ecc_inj_decoder.sv
module ecc_inj_decoder
    import ecc_inj_pkg::*;
(
    input  codeword_t         cw,
    output logic [DATA_W-1:0] fixed_data,
    output ecc_class_e        cls
);

    localparam logic [HAM_W-1:0] MAX_POS = HAM_W'(CODE_W);

    logic [HAM_W-1:0] syndrome;
    logic             par_bad;
    logic             is_single;

    always_comb begin
        syndrome = hamming_bits(cw.data) ^ cw.chk[HAM_W-1:0];
        par_bad  = ^cw;
        if (!par_bad) begin
            cls = (syndrome == '0) ? ECC_CLEAN : ECC_DOUBLE;
        end else begin
            cls = (syndrome <= MAX_POS) ? ECC_SINGLE : ECC_DOUBLE;
        end
    end

    assign is_single = (cls == ECC_SINGLE);

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fix
        localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(gi));
        assign fixed_data[gi] = cw.data[gi] ^ (is_single && (syndrome == POS));
    end

endmodule

// File: rtl/ecc_inj_accounting.sv
module ecc_inj_accounting
    import ecc_inj_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  ecc_class_e       ev_class,
    input  logic [CNT_W-1:0] threshold,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             clr_we,
    input  logic [2:0]       clr_bits,
    output logic [CNT_W-1:0] count,
    output logic             flag_sbe,
    output logic             flag_mbe,
    output logic             flag_multi
);

    logic             sb_hit;
    logic             mb_hit;
    logic             wrap;
    logic [CNT_W-1:0] next_cnt;

    assign sb_hit   = ev_valid && (ev_class == ECC_SINGLE);
    assign mb_hit   = ev_valid && (ev_class == ECC_DOUBLE);
    assign next_cnt = count + CNT_W'(1);
    assign wrap     = sb_hit && (next_cnt == threshold);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            flag_sbe   <= 1'b0;
            flag_mbe   <= 1'b0;
            flag_multi <= 1'b0;
        end else begin
            if (cnt_we)       count <= cnt_wdata;
            else if (sb_hit)  count <= wrap ? '0 : next_cnt;

            if (clr_we && clr_bits[0]) flag_sbe <= 1'b0;
            else if (wrap)             flag_sbe <= 1'b1;

            if (clr_we && clr_bits[1]) flag_mbe <= 1'b0;
            else if (mb_hit)           flag_mbe <= 1'b1;

            if (clr_we && clr_bits[2])                           flag_multi <= 1'b0;
            else if ((wrap && flag_sbe) || (mb_hit && flag_mbe)) flag_multi <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_inject_guard.sv
module ecc_inject_guard
    import ecc_inj_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_wr_valid,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [CHK_W-1:0]  mem_wr_check,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    output logic              rd_out_valid,
    output logic [DATA_W-1:0] rd_out_data,
    output logic              rd_corrected,
    output logic              rd_uncorrectable,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [REG_DW-1:0] cfg_wdata,
    output logic [CNT_W-1:0]  sb_count,
    output logic              flag_sbe,
    output logic              flag_mbe,
    output logic              flag_multi
);

    logic [HALF_W-1:0] mask_lo;
    logic [HALF_W-1:0] mask_hi;
    logic              inj_en;
    logic [CNT_W-1:0]  threshold;
    logic              cnt_we;
    logic              clr_we;
    codeword_t         enc_word;
    codeword_t         rd_word;
    logic [DATA_W-1:0] dec_data;
    ecc_class_e        dec_class;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_lo   <= '0;
            mask_hi   <= '0;
            inj_en    <= 1'b0;
            threshold <= '1;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_MASK_LO: mask_lo   <= cfg_wdata;
                REG_MASK_HI: mask_hi   <= cfg_wdata;
                REG_CTRL:    inj_en    <= cfg_wdata[0];
                REG_THRESH:  threshold <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign cnt_we = cfg_we && (cfg_addr == REG_COUNT);
    assign clr_we = cfg_we && (cfg_addr == REG_CLEAR);

    ecc_inj_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .inj_en   (inj_en),
        .inj_mask ({mask_hi, mask_lo}),
        .out_valid(mem_wr_valid),
        .out_word (enc_word)
    );

    assign mem_wr_data  = enc_word.data;
    assign mem_wr_check = enc_word.chk;

    assign rd_word.data = rd_data;
    assign rd_word.chk  = rd_check;

    ecc_inj_decoder u_dec (
        .cw        (rd_word),
        .fixed_data(dec_data),
        .cls       (dec_class)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out_valid     <= 1'b0;
            rd_out_data      <= '0;
            rd_corrected     <= 1'b0;
            rd_uncorrectable <= 1'b0;
        end else begin
            rd_out_valid     <= rd_valid;
            rd_out_data      <= dec_data;
            rd_corrected     <= rd_valid && (dec_class == ECC_SINGLE);
            rd_uncorrectable <= rd_valid && (dec_class == ECC_DOUBLE);
        end
    end

    ecc_inj_accounting #(.CNT_W(CNT_W)) u_acct (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (rd_valid),
        .ev_class  (dec_class),
        .threshold (threshold),
        .cnt_we    (cnt_we),
        .cnt_wdata (cfg_wdata[CNT_W-1:0]),
        .clr_we    (clr_we),
        .clr_bits  (cfg_wdata[2:0]),
        .count     (sb_count),
        .flag_sbe  (flag_sbe),
        .flag_mbe  (flag_mbe),
        .flag_multi(flag_multi)
    );

endmodule

// File: rtl/ecc_inject_guard_chk.sv
module ecc_inject_guard_chk
    import ecc_inj_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic              inj_en,
    input logic              mem_wr_valid,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              rd_valid,
    input logic              rd_out_valid,
    input logic              rd_corrected,
    input logic              rd_uncorrectable,
    input logic              cfg_we,
    input logic [REG_AW-1:0] cfg_addr,
    input logic [2:0]        clr_bits,
    input logic              flag_sbe,
    input logic              flag_mbe,
    input logic              flag_multi
);

    logic clr_sbe;
    logic clr_mbe;

    assign clr_sbe = cfg_we && (cfg_addr == REG_CLEAR) && clr_bits[0];
    assign clr_mbe = cfg_we && (cfg_addr == REG_CLEAR) && clr_bits[1];

    AST_WR_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !inj_en) |=> (mem_wr_valid && (mem_wr_data == $past(wr_data)))); // R2

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> rd_out_valid); // R4

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_corrected && rd_uncorrectable)); // R5

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_out_valid |-> (!rd_corrected && !rd_uncorrectable)); // R6

    AST_MBE_ON_UNCORR: assert property (@(posedge clk) disable iff (rst)
        (rd_uncorrectable && !$past(clr_mbe)) |-> flag_mbe); // R10

    AST_MULTI_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_multi) |-> ($past(flag_sbe) || $past(flag_mbe))); // R9

    AST_SBE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_sbe && !clr_sbe) |=> flag_sbe); // R12

endmodule

bind ecc_inject_guard ecc_inject_guard_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_valid        (wr_valid),
    .wr_data         (wr_data),
    .inj_en          (inj_en),
    .mem_wr_valid    (mem_wr_valid),
    .mem_wr_data     (mem_wr_data),
    .rd_valid        (rd_valid),
    .rd_out_valid    (rd_out_valid),
    .rd_corrected    (rd_corrected),
    .rd_uncorrectable(rd_uncorrectable),
    .cfg_we          (cfg_we),
    .cfg_addr        (cfg_addr),
    .clr_bits        (cfg_wdata[2:0]),
    .flag_sbe        (flag_sbe),
    .flag_mbe        (flag_mbe),
    .flag_multi      (flag_multi)
);

// File: tb/ecc_inject_guard_tb.sv
module ecc_inject_guard_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [63:0] wr_data;
    logic        mem_wr_valid;
    logic [63:0] mem_wr_data;
    logic [7:0]  mem_wr_check;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [7:0]  rd_check;
    logic        rd_out_valid;
    logic [63:0] rd_out_data;
    logic        rd_corrected;
    logic        rd_uncorrectable;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [7:0]  sb_count;
    logic        flag_sbe;
    logic        flag_mbe;
    logic        flag_multi;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [63:0] cap_data;
    logic [7:0]  cap_chk;

    ecc_inject_guard u_dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data), .mem_wr_check(mem_wr_check),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
        .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data),
        .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sb_count(sb_count), .flag_sbe(flag_sbe), .flag_mbe(flag_mbe), .flag_multi(flag_multi)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_word(input logic [63:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        cap_data = mem_wr_data;
        cap_chk  = mem_wr_check;
        check(mem_wr_valid === 1'b1, "R2", "write valid", 64'(mem_wr_valid), 64'd1);
    endtask

    task automatic read_word(input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        rd_valid = 1'b1; rd_data = d; rd_check = c;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic read_expect(input logic [63:0] d, input logic [7:0] c,
                               input logic [63:0] exp_data, input bit exp_corr,
                               input bit exp_unc, input string req);
        read_word(d, c);
        check(rd_out_valid === 1'b1, req, "read valid", 64'(rd_out_valid), 64'd1);
        check(rd_out_data === exp_data, req, "read data", rd_out_data, exp_data);
        check(rd_corrected === exp_corr, req, "corrected strobe", 64'(rd_corrected), 64'(exp_corr));
        check(rd_uncorrectable === exp_unc, req, "uncorrectable strobe",
              64'(rd_uncorrectable), 64'(exp_unc));
    endtask

    function automatic logic [71:0] flip72(input logic [71:0] cw, input int k);
        logic [71:0] r;
        r = cw;
        r[k] = ~r[k];
        return r;
    endfunction

    task automatic check_flags(input bit s, input bit m, input bit x, input string req);
        check(flag_sbe === s, req, "single-error flag", 64'(flag_sbe), 64'(s));
        check(flag_mbe === m, req, "multi-bit flag", 64'(flag_mbe), 64'(m));
        check(flag_multi === x, req, "repeat flag", 64'(flag_multi), 64'(x));
    endtask

    initial begin
        #1_500_000;
        $display("FAIL watchdog expired");
        failures++;
        checks++;
        finish_run();
    end

    initial begin
        logic [63:0] d0;
        logic [7:0]  c0;
        logic [71:0] cw0;
        logic [71:0] cw;
        logic [7:0]  clean_chk;
        int          cnt_exp;

        rst = 1'b1; wr_valid = 0; wr_data = '0; rd_valid = 0; rd_data = '0; rd_check = '0;
        cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(mem_wr_valid === 1'b0, "R1", "write valid after reset", 64'(mem_wr_valid), 0);
        check(rd_out_valid === 1'b0, "R1", "read valid after reset", 64'(rd_out_valid), 0);
        check(sb_count === 8'd0, "R1", "counter after reset", 64'(sb_count), 0);
        check_flags(0, 0, 0, "R1");

        // R2/R6: walking ones and fixed patterns, clean round trip
        for (int i = 0; i < 68; i++) begin
            logic [63:0] p;
            if (i < 64)       p = 64'd1 << i;
            else if (i == 64) p = 64'd0;
            else if (i == 65) p = '1;
            else if (i == 66) p = 64'hA5A5_5A5A_C3C3_3C3C;
            else              p = 64'h0123_4567_89AB_CDEF;
            write_word(p);
            check(cap_data === p, "R2", "stored data", cap_data, p);
            read_expect(cap_data, cap_chk, p, 0, 0, "R6");
        end
        check(sb_count === 8'd0, "R7", "counter after clean reads", 64'(sb_count), 0);

        d0 = 64'h0123_4567_89AB_CDEF;
        write_word(d0);
        c0 = cap_chk;
        clean_chk = cap_chk;
        cw0 = {d0, c0};

        // R2: masks programmed but injection disabled
        cfg_write(3'd0, 32'h0000_0001);
        write_word(d0);
        check(cap_data === d0, "R2", "masked data while disabled", cap_data, d0);

        // R3/R4: one mask bit with injection on
        cfg_write(3'd2, 32'd1);
        write_word(d0);
        check(cap_data === (d0 ^ 64'd1), "R3", "injected data", cap_data, d0 ^ 64'd1);
        check(cap_chk === clean_chk, "R3", "check bits from clean data", 64'(cap_chk), 64'(clean_chk));
        read_expect(cap_data, cap_chk, d0, 1, 0, "R4");
        cnt_exp = 1;

        // R3/R4: single bit in high half
        cfg_write(3'd0, 32'h0);
        cfg_write(3'd1, 32'h8000_0000);
        write_word(d0);
        check(cap_data === (d0 ^ 64'h8000_0000_0000_0000), "R3", "high-half injection",
              cap_data, d0 ^ 64'h8000_0000_0000_0000);
        read_expect(cap_data, cap_chk, d0, 1, 0, "R4");
        cnt_exp++;

        // R5: two bits in low half
        cfg_write(3'd1, 32'h0);
        cfg_write(3'd0, 32'h3);
        write_word(d0);
        read_expect(cap_data, cap_chk, d0 ^ 64'h3, 0, 1, "R5");

        // R5: one bit in each half
        cfg_write(3'd1, 32'h1);
        cfg_write(3'd0, 32'h1);
        write_word(d0);
        read_expect(cap_data, cap_chk, d0 ^ 64'h0000_0001_0000_0001, 0, 1, "R5");
        cfg_write(3'd2, 32'd0);

        // R4: every single-bit position of the 72-bit codeword
        for (int k = 0; k < 72; k++) begin
            cw = flip72(cw0, k);
            read_expect(cw[71:8], cw[7:0], d0, 1, 0, "R4");
            cnt_exp++;
        end
        check(sb_count === 8'(cnt_exp), "R7", "counter after single sweep",
              64'(sb_count), 64'(cnt_exp));
        check(flag_sbe === 1'b0, "R7", "single flag below threshold", 64'(flag_sbe), 0);

        // R10: first and second uncorrectable read
        cfg_write(3'd5, 32'h7);
        check_flags(0, 0, 0, "R11");
        cw = flip72(flip72(cw0, 0), 1);
        read_expect(cw[71:8], cw[7:0], cw[71:8], 0, 1, "R5");
        check_flags(0, 1, 0, "R10");
        cw = flip72(flip72(cw0, 64), 70);
        read_expect(cw[71:8], cw[7:0], cw[71:8], 0, 1, "R5");
        check_flags(0, 1, 1, "R10");

        // R5: pair sweep
        for (int k = 0; k < 72; k++) begin
            cw = flip72(flip72(cw0, k), (k + 1) % 72);
            read_expect(cw[71:8], cw[7:0], cw[71:8], 0, 1, "R5");
            cw = flip72(flip72(cw0, k), (k + 37) % 72);
            read_expect(cw[71:8], cw[7:0], cw[71:8], 0, 1, "R5");
        end
        check(sb_count === 8'(cnt_exp), "R7", "counter unchanged by uncorrectable reads",
              64'(sb_count), 64'(cnt_exp));

        // R8/R9: threshold 4
        cfg_write(3'd5, 32'h7);
        cfg_write(3'd4, 32'd0);
        cfg_write(3'd3, 32'd4);
        cw = flip72(cw0, 5);
        for (int n = 1; n <= 3; n++) begin
            read_word(cw[71:8], cw[7:0]);
            check(sb_count === 8'(n), "R7", "counter below threshold", 64'(sb_count), 64'(n));
            check(flag_sbe === 1'b0, "R7", "single flag below threshold", 64'(flag_sbe), 0);
        end
        read_word(cw[71:8], cw[7:0]);
        check(sb_count === 8'd0, "R8", "counter wraps at threshold", 64'(sb_count), 0);
        check_flags(1, 0, 0, "R8");
        for (int n = 0; n < 4; n++) read_word(cw[71:8], cw[7:0]);
        check(sb_count === 8'd0, "R9", "counter wraps again", 64'(sb_count), 0);
        check_flags(1, 0, 1, "R9");

        // R12: flags hold through clean reads
        for (int n = 0; n < 10; n++) read_word(cw0[71:8], cw0[7:0]);
        check_flags(1, 0, 1, "R12");

        // R11: clear only the single-error flag
        cfg_write(3'd5, 32'h1);
        check_flags(0, 0, 1, "R11");
        cfg_write(3'd5, 32'h4);
        check_flags(0, 0, 0, "R11");

        // R11: counter write wins over a same-cycle corrected read
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'd200;
        rd_valid = 1'b1; rd_data = cw[71:8]; rd_check = cw[7:0];
        @(negedge clk);
        cfg_we = 1'b0; rd_valid = 1'b0;
        check(rd_corrected === 1'b1, "R4", "corrected strobe with counter write", 64'(rd_corrected), 1);
        check(sb_count === 8'd200, "R11", "counter write priority", 64'(sb_count), 64'd200);
        read_word(cw[71:8], cw[7:0]);
        check(sb_count === 8'd201, "R7", "counter after write", 64'(sb_count), 64'd201);

        // R7: 16 errors against threshold 255 leave the flag clear
        cfg_write(3'd3, 32'd255);
        cfg_write(3'd4, 32'd0);
        for (int n = 0; n < 16; n++) read_word(cw[71:8], cw[7:0]);
        check(sb_count === 8'd16, "R7", "sixteen corrected reads", 64'(sb_count), 64'd16);
        check_flags(0, 0, 0, "R7");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule